// File: doc/BRIEF.md
# Station Address PROM Port Decoder

This block sits at the front of a network controller's I/O window and decodes every host access into it. The lowest sixteen bytes of the window hold a small station-address PROM. The block keeps that PROM in its own storage, loads it from a parameter at reset, and lets the host read it or, when a write-enable control is set, rewrite it. Any access above those sixteen bytes goes out on a forwarding port to the controller's register file, which lies outside this block.

Each access carries an offset, a size code and a write flag. The size code is 0 for a byte, 1 for 16 bits, 2 for 32 bits, and 3 is reserved. A mode input picks 16-bit or 32-bit I/O, and this choice decides which sizes the PROM accepts. Multi-byte values are little-endian: the byte at the lowest offset sits in bits 7:0.

Accesses arrive on a valid/ready channel. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` drops only while a forwarded read is in flight, and the requester must hold the request steady until it is taken. Each taken read produces exactly one single-cycle `rsp_valid` pulse. This pulse cannot be stalled. Writes produce no response.

Top module: `staddr_io_front`

## Requirements
- R1: After reset the PROM holds the `INIT_ADDR` parameter, with byte j taken from bits 8j+7:8j. `req_ready` is high, and `rsp_valid` and `fwd_valid` are low.
- R2: With `io32_mode`=0, a byte read at an offset below 16 returns PROM byte (offset mod 16) in bits 7:0, with the upper bits zero. `rsp_valid` is high in the cycle after the request is taken.
- R3: With `io32_mode`=0, a 16-bit read at an even offset below 16 returns byte n in bits 7:0 and byte n+1 in bits 15:8, with the upper bits zero.
- R4: With `io32_mode`=1, a 32-bit read at a 4-aligned offset below 16 returns bytes n..n+3, with byte n in bits 7:0.
- R5: A PROM read that matches no legal case returns all ones of the requested width: 0xFF, 0xFFFF or 0xFFFFFFFF. The reserved size returns 0xFFFFFFFF. Non-legal cases are: a 32-bit or reserved size in 16-bit mode, an odd 16-bit offset, any non-32-bit size in 32-bit mode, and a misaligned 32-bit access.
- R6: A legal PROM write stores its bytes in little-endian order only when `prom_we`=1. With `prom_we`=0 the PROM is unchanged.
- R7: A PROM write with an illegal size or alignment for the current mode leaves the PROM unchanged, even with `prom_we`=1.
- R8: At offset 16 or above, a taken 16-bit or 32-bit access gives a one-cycle `fwd_valid` strobe in the next cycle. The strobe carries the request's offset, size, write flag and write data.
- R9: A forwarded read gives `rsp_valid` two cycles after its strobe. If `fwd_rvalid` was high in the cycle after the strobe, the response is `fwd_rdata` masked to the access width. Otherwise it is all ones of that width.
- R10: At offset 16 or above, a byte or reserved-size access raises no strobe. A write of this kind has no effect, and a read returns all ones of the requested width one cycle after it is taken.
- R11: `req_ready` is low from the strobe of a forwarded read until its response. Writes never produce `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| req_offset | input | OFS_W | Byte offset in the I/O window |
| req_wdata | input | 32 | Write data, little-endian lanes |
| prom_we | input | 1 | PROM write enable |
| io32_mode | input | 1 | 1 = 32-bit I/O mode |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 32 | Read data |
| fwd_valid | output | 1 | Forwarding request strobe |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_size | output | 2 | Forwarded size code |
| fwd_offset | output | OFS_W | Forwarded offset |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_rvalid | input | 1 | Register-port read data valid |
| fwd_rdata | input | 32 | Register-port read data |

## Verification
The three kinds of result arrive at different times after the clock edge that takes the request:
- PROM reads and rejected reads respond one edge later.
- The forwarding strobe appears one edge later.
- A forwarded read responds three edges later, and the register-port reply must be driven in the second cycle.

The bench drives and samples at the falling edge. Each task waits the exact number of falling edges for that path before it compares, and it also checks that no response or strobe shows up in the cycles before it is due. PROM writes are checked by reading the bytes back afterwards.

// File: rtl/staddr_pkg.sv
package staddr_pkg;

  localparam int PROM_BYTES = 16;
  localparam int PROM_IDX_W = $clog2(PROM_BYTES);
  localparam int LANES      = 4;
  localparam int DATA_W     = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef struct packed {
    logic             in_prom;
    logic             prom_ok;
    logic             fwd_ok;
    logic [LANES-1:0] lanes;
  } dec_t;

  // all-ones value (and data mask) of an access width
  function automatic logic [DATA_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_HALF: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/staddr_decode.sv
module staddr_decode
  import staddr_pkg::*;
#(
  parameter int OFS_W = 5
) (
  input  logic [OFS_W-1:0] offset,
  input  logic [1:0]       size,
  input  logic             io32,
  output dec_t             dec
);

  always_comb begin
    dec         = '0;
    dec.in_prom = (offset[OFS_W-1:PROM_IDX_W] == '0);
    if (dec.in_prom) begin
      if (!io32) begin
        if (size == SZ_BYTE) begin
          dec.prom_ok = 1'b1;
          dec.lanes   = 4'b0001;
        end else if (size == SZ_HALF && !offset[0]) begin
          dec.prom_ok = 1'b1;
          dec.lanes   = 4'b0011;
        end
      end else if (size == SZ_WORD && offset[1:0] == 2'b00) begin
        dec.prom_ok = 1'b1;
        dec.lanes   = 4'b1111;
      end
    end else begin
      dec.fwd_ok = (size == SZ_HALF) || (size == SZ_WORD);
    end
  end

endmodule

// File: rtl/staddr_prom.sv
module staddr_prom
  import staddr_pkg::*;
#(
  parameter logic [8*PROM_BYTES-1:0] INIT_ADDR = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PROM_IDX_W-1:0] base,
  input  logic [LANES-1:0]      lanes,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata
);

  logic [8*PROM_BYTES-1:0] flat;

  for (genvar j = 0; j < PROM_BYTES; j++) begin : g_cell
    localparam logic [PROM_IDX_W-1:0] IDX = PROM_IDX_W'(j);
    logic [PROM_IDX_W-1:0] rel;
    logic                  hit;
    logic [7:0]            q;

    assign rel = IDX - base;
    assign hit = wr_en && (rel[PROM_IDX_W-1:2] == '0) && lanes[rel[1:0]];

    always_ff @(posedge clk) begin
      if (!rst_n)   q <= INIT_ADDR[8*j +: 8];
      else if (hit) q <= wdata[8*rel[1:0] +: 8];
    end

    assign flat[8*j +: 8] = q;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [PROM_IDX_W-1:0] idx;
    assign idx = base + PROM_IDX_W'(i);
    assign rdata[8*i +: 8] = lanes[i] ? flat[8*idx +: 8] : 8'h00;
  end

endmodule

// File: rtl/staddr_fwd.sv
module staddr_fwd
  import staddr_pkg::*;
#(
  parameter int OFS_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              in_write,
  input  logic [1:0]        in_size,
  input  logic [OFS_W-1:0]  in_offset,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [1:0]        fwd_size,
  output logic [OFS_W-1:0]  fwd_offset,
  output logic [DATA_W-1:0] fwd_wdata,
  input  logic              fwd_rvalid,
  input  logic [DATA_W-1:0] fwd_rdata,
  output logic              busy,
  output logic              rd_done,
  output logic [DATA_W-1:0] rd_data
);

  logic reply_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid  <= 1'b0;
      fwd_write  <= 1'b0;
      fwd_size   <= '0;
      fwd_offset <= '0;
      fwd_wdata  <= '0;
      reply_slot <= 1'b0;
    end else begin
      fwd_valid  <= launch;
      reply_slot <= fwd_valid && !fwd_write;
      if (launch) begin
        fwd_write  <= in_write;
        fwd_size   <= in_size;
        fwd_offset <= in_offset;
        fwd_wdata  <= in_wdata;
      end
    end
  end

  assign busy    = (fwd_valid && !fwd_write) || reply_slot;
  assign rd_done = reply_slot;
  assign rd_data = fwd_rvalid ? (fwd_rdata & size_mask(fwd_size))
                              : size_mask(fwd_size);

endmodule

// File: rtl/staddr_io_front.sv
module staddr_io_front
  import staddr_pkg::*;
#(
  parameter int                      OFS_W     = 5,
  parameter logic [8*PROM_BYTES-1:0] INIT_ADDR = 128'h0000_0000_0000_0000_0000_5634_1200_5452
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [OFS_W-1:0] req_offset,
  input  logic [31:0]      req_wdata,
  input  logic             prom_we,
  input  logic             io32_mode,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             fwd_valid,
  output logic             fwd_write,
  output logic [1:0]       fwd_size,
  output logic [OFS_W-1:0] fwd_offset,
  output logic [31:0]      fwd_wdata,
  input  logic             fwd_rvalid,
  input  logic [31:0]      fwd_rdata
);

  dec_t              dec;
  logic              take;
  logic              busy;
  logic              fwd_done;
  logic [DATA_W-1:0] fwd_rd;
  logic [DATA_W-1:0] prom_rd;
  logic              prom_wr;
  logic              local_rd;
  logic [DATA_W-1:0] local_data;

  assign req_ready = !busy;
  assign take      = req_valid && req_ready;

  staddr_decode #(.OFS_W(OFS_W)) u_dec (
    .offset (req_offset),
    .size   (req_size),
    .io32   (io32_mode),
    .dec    (dec)
  );

  assign prom_wr = take && req_write && dec.in_prom && dec.prom_ok && prom_we;

  staddr_prom #(.INIT_ADDR(INIT_ADDR)) u_prom (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (prom_wr),
    .base  (req_offset[PROM_IDX_W-1:0]),
    .lanes (dec.lanes),
    .wdata (req_wdata),
    .rdata (prom_rd)
  );

  staddr_fwd #(.OFS_W(OFS_W)) u_fwd (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (take && dec.fwd_ok),
    .in_write   (req_write),
    .in_size    (req_size),
    .in_offset  (req_offset),
    .in_wdata   (req_wdata),
    .fwd_valid  (fwd_valid),
    .fwd_write  (fwd_write),
    .fwd_size   (fwd_size),
    .fwd_offset (fwd_offset),
    .fwd_wdata  (fwd_wdata),
    .fwd_rvalid (fwd_rvalid),
    .fwd_rdata  (fwd_rdata),
    .busy       (busy),
    .rd_done    (fwd_done),
    .rd_data    (fwd_rd)
  );

  assign local_rd   = take && !req_write && !dec.fwd_ok;
  assign local_data = (dec.in_prom && dec.prom_ok) ? prom_rd : size_mask(req_size);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= local_rd || fwd_done;
      if (fwd_done)      rsp_rdata <= fwd_rd;
      else if (local_rd) rsp_rdata <= local_data;
    end
  end

endmodule

// File: rtl/staddr_io_front_chk.sv
module staddr_io_front_chk #(
  parameter int OFS_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic [1:0]       req_size,
  input logic [OFS_W-1:0] req_offset,
  input logic [31:0]      req_wdata,
  input logic             rsp_valid,
  input logic [31:0]      rsp_rdata,
  input logic             fwd_valid,
  input logic             fwd_write,
  input logic [1:0]       fwd_size,
  input logic [OFS_W-1:0] fwd_offset,
  input logic [31:0]      fwd_wdata
);

  logic taken, hi_ofs, fwd_sz;
  assign taken  = req_valid && req_ready;
  assign hi_ofs = (req_offset[OFS_W-1:4] != '0);
  assign fwd_sz = (req_size == 2'd1) || (req_size == 2'd2);

  // R2: a read below offset 16 answers on the next cycle
  p_prom_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !req_write && !hi_ofs) |=> rsp_valid);

  // R5: reserved size read in the PROM region returns 32 ones
  p_rsvd_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && !req_write && !hi_ofs && req_size == 2'd3) |=> (rsp_rdata == 32'hFFFF_FFFF));

  // R8: forwarded access strobes once with the request fields
  p_fwd_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && hi_ofs && fwd_sz) |=> (fwd_valid && fwd_offset == $past(req_offset)
                                     && fwd_size == $past(req_size)
                                     && fwd_write == $past(req_write)
                                     && fwd_wdata == $past(req_wdata)));

  p_fwd_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |=> !fwd_valid);

  // R9: forwarded read responds two cycles after its strobe
  p_fwd_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_write) |-> ##2 rsp_valid);

  // R10: byte or reserved size above the PROM never strobes
  p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && (!hi_ofs || !fwd_sz)) |=> !fwd_valid);

  // R11: no new request while a forwarded read is open; writes get no reply
  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_write) |-> !req_ready);

  p_wr_no_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (taken && req_write) |=> !rsp_valid);

endmodule

bind staddr_io_front staddr_io_front_chk #(.OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_size   (req_size),
  .req_offset (req_offset),
  .req_wdata  (req_wdata),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .fwd_valid  (fwd_valid),
  .fwd_write  (fwd_write),
  .fwd_size   (fwd_size),
  .fwd_offset (fwd_offset),
  .fwd_wdata  (fwd_wdata)
);

// File: tb/staddr_io_front_tb.sv
module staddr_io_front_tb;

  localparam int OFS_W = 5;
  localparam logic [127:0] TB_INIT = 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic             req_write = 1'b0;
  logic [1:0]       req_size = '0;
  logic [OFS_W-1:0] req_offset = '0;
  logic [31:0]      req_wdata = '0;
  logic             prom_we = 1'b0;
  logic             io32_mode = 1'b0;
  logic             rsp_valid;
  logic [31:0]      rsp_rdata;
  logic             fwd_valid;
  logic             fwd_write;
  logic [1:0]       fwd_size;
  logic [OFS_W-1:0] fwd_offset;
  logic [31:0]      fwd_wdata;
  logic             fwd_rvalid = 1'b0;
  logic [31:0]      fwd_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] prom_m [16];

  always #10 clk = ~clk;

  staddr_io_front #(.OFS_W(OFS_W), .INIT_ADDR(TB_INIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_offset(req_offset),
    .req_wdata(req_wdata), .prom_we(prom_we), .io32_mode(io32_mode),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .fwd_valid(fwd_valid),
    .fwd_write(fwd_write), .fwd_size(fwd_size), .fwd_offset(fwd_offset),
    .fwd_wdata(fwd_wdata), .fwd_rvalid(fwd_rvalid), .fwd_rdata(fwd_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ones(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic bit legal(input logic [1:0] sz, input logic [3:0] o, input bit m32);
    if (!m32) return (sz == 2'd0) || (sz == 2'd1 && !o[0]);
    return sz == 2'd2 && o[1:0] == 2'b00;
  endfunction

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_prom(input logic [1:0] sz, input logic [3:0] o);
    logic [31:0] v = '0;
    if (!legal(sz, o, io32_mode)) return ones(sz);
    for (int k = 0; k < nbytes(sz); k++) v[8*k +: 8] = prom_m[4'(o + 4'(k))];
    return v;
  endfunction

  // present one request and return in the cycle after it is taken
  task automatic send(input bit wr, input logic [1:0] sz, input logic [OFS_W-1:0] o,
                      input logic [31:0] wd);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_offset = o; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic prom_rd(input string tag, input logic [1:0] sz, input logic [3:0] o);
    logic [31:0] e = exp_prom(sz, o);
    send(1'b0, sz, {1'b0, o}, '0);
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " data"}, rsp_rdata, e);
    chk({tag, " no strobe"}, 32'(fwd_valid), 32'd0);
  endtask

  task automatic prom_wr(input string tag, input logic [1:0] sz, input logic [3:0] o,
                         input logic [31:0] wd);
    if (prom_we && legal(sz, o, io32_mode))
      for (int k = 0; k < nbytes(sz); k++) prom_m[4'(o + 4'(k))] = wd[8*k +: 8];
    send(1'b1, sz, {1'b0, o}, wd);
    chk({tag, " no rsp R11"}, 32'(rsp_valid), 32'd0);
  endtask

  task automatic verify_all(input string tag);
    bit save = io32_mode;
    io32_mode = 1'b0;
    for (int j = 0; j < 16; j++) prom_rd(tag, 2'd0, 4'(j));
    io32_mode = save;
  endtask

  task automatic t_reset;
    chk("R1 ready", 32'(req_ready), 32'd1);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 fwd_valid", 32'(fwd_valid), 32'd0);
    verify_all("R1/R2 reset byte");
  endtask

  task automatic t_half;
    io32_mode = 1'b0;
    prom_rd("R3 half@0", 2'd1, 4'd0);
    prom_rd("R3 half@6", 2'd1, 4'd6);
    prom_rd("R3 half@14", 2'd1, 4'd14);
    prom_rd("R5 half odd", 2'd1, 4'd3);
    prom_rd("R5 word in 16b", 2'd2, 4'd4);
    prom_rd("R5 rsvd", 2'd3, 4'd0);
  endtask

  task automatic t_word;
    io32_mode = 1'b1;
    prom_rd("R4 word@0", 2'd2, 4'd0);
    prom_rd("R4 word@12", 2'd2, 4'd12);
    prom_rd("R5 byte in 32b", 2'd0, 4'd1);
    prom_rd("R5 half in 32b", 2'd1, 4'd2);
    prom_rd("R5 word misaligned", 2'd2, 4'd2);
    io32_mode = 1'b0;
  endtask

  task automatic t_write;
    io32_mode = 1'b0; prom_we = 1'b0;
    prom_wr("R6 we off", 2'd0, 4'd5, 32'h0000_00AA);
    prom_wr("R6 we off half", 2'd1, 4'd8, 32'h0000_BBCC);
    verify_all("R6 unchanged");
    prom_we = 1'b1;
    prom_wr("R6 byte", 2'd0, 4'd5, 32'h0000_00AA);
    prom_wr("R6 half", 2'd1, 4'd8, 32'h0000_BBCC);
    io32_mode = 1'b1;
    prom_wr("R6 word", 2'd2, 4'd12, 32'h4433_2211);
    prom_wr("R7 byte in 32b", 2'd0, 4'd1, 32'h0000_0099);
    prom_wr("R7 word misaligned", 2'd2, 4'd6, 32'h8877_6655);
    io32_mode = 1'b0;
    prom_wr("R7 half odd", 2'd1, 4'd3, 32'h0000_7766);
    prom_wr("R7 word in 16b", 2'd2, 4'd0, 32'hDEAD_BEEF);
    prom_wr("R7 rsvd", 2'd3, 4'd4, 32'h1234_5678);
    prom_we = 1'b0;
    verify_all("R6/R7 readback");
    io32_mode = 1'b1;
    prom_rd("R4/R6 word readback", 2'd2, 4'd12);
    io32_mode = 1'b0;
  endtask

  task automatic t_fwd_write;
    send(1'b1, 2'd2, 5'h14, 32'h0BAD_F00D);
    chk("R8 strobe", 32'(fwd_valid), 32'd1);
    chk("R8 offset", 32'(fwd_offset), 32'h14);
    chk("R8 size", 32'(fwd_size), 32'd2);
    chk("R8 write", 32'(fwd_write), 32'd1);
    chk("R8 wdata", fwd_wdata, 32'h0BAD_F00D);
    chk("R11 no rsp fwd write", 32'(rsp_valid), 32'd0);
    @(negedge clk);
    chk("R8 one cycle", 32'(fwd_valid), 32'd0);
    send(1'b1, 2'd1, 5'h11, 32'h0000_5A5A);
    chk("R8 half strobe", 32'(fwd_valid), 32'd1);
    chk("R8 half offset", 32'(fwd_offset), 32'h11);
    send(1'b1, 2'd0, 5'h18, 32'h0000_0077);
    chk("R10 byte write no strobe", 32'(fwd_valid), 32'd0);
    chk("R10 byte write no rsp", 32'(rsp_valid), 32'd0);
    send(1'b0, 2'd0, 5'h1F, '0);
    chk("R10 byte read rsp", 32'(rsp_valid), 32'd1);
    chk("R10 byte read ones", rsp_rdata, 32'hFF);
    chk("R10 byte read no strobe", 32'(fwd_valid), 32'd0);
    send(1'b0, 2'd3, 5'h10, '0);
    chk("R10 rsvd read ones", rsp_rdata, 32'hFFFF_FFFF);
  endtask

  task automatic fwd_read(input string tag, input logic [1:0] sz, input logic [OFS_W-1:0] o,
                          input bit give, input logic [31:0] d, input logic [31:0] e);
    send(1'b0, sz, o, '0);
    chk({tag, " strobe"}, 32'(fwd_valid), 32'd1);
    chk({tag, " rd flag"}, 32'(fwd_write), 32'd0);
    chk({tag, " offset"}, 32'(fwd_offset), 32'(o));
    chk({tag, " R11 ready low"}, 32'(req_ready), 32'd0);
    chk({tag, " no early rsp"}, 32'(rsp_valid), 32'd0);
    @(negedge clk);
    fwd_rvalid = give; fwd_rdata = d;
    chk({tag, " R11 ready low 2"}, 32'(req_ready), 32'd0);
    chk({tag, " no early rsp 2"}, 32'(rsp_valid), 32'd0);
    @(negedge clk);
    fwd_rvalid = 1'b0; fwd_rdata = '0;
    chk({tag, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " data"}, rsp_rdata, e);
    chk({tag, " R11 ready back"}, 32'(req_ready), 32'd1);
    @(negedge clk);
    chk({tag, " rsp one cycle"}, 32'(rsp_valid), 32'd0);
  endtask

  task automatic t_fwd_read;
    fwd_read("R9 word", 2'd2, 5'h10, 1'b1, 32'hCAFE_F00D, 32'hCAFE_F00D);
    fwd_read("R9 half masked", 2'd1, 5'h1E, 1'b1, 32'h1234_ABCD, 32'h0000_ABCD);
    fwd_read("R9 no reply", 2'd1, 5'h12, 1'b0, 32'h0, 32'h0000_FFFF);
    fwd_read("R9 word no reply", 2'd2, 5'h1C, 1'b0, 32'h0, 32'hFFFF_FFFF);
  endtask

  bit finished = 1'b0;

  initial begin
    for (int j = 0; j < 16; j++) prom_m[j] = TB_INIT[8*j +: 8];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_half();
    t_word();
    t_write();
    t_fwd_write();
    t_fwd_read();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule